// File: doc/BRIEF.md
# Conversion-Complete Flag Register with Threshold Compare

This block keeps one completion flag per position in an analog-to-digital conversion sequence. It is placed next to a sequence controller. Each time a conversion finishes, the controller pulses a done strobe, gives the position of that conversion in the sequence, and supplies the converted 12-bit value. Flags are indexed by sequence position, not by input channel. The block has eight flags, eight result registers and a small configuration set. All of them are reached through a simple register bus with separate read and write strobes.

Each slot runs in one of two modes. In store mode, a finished conversion writes its value into that slot's result register and sets the slot's flag. In compare mode, the result register holds a threshold instead. The converted value is tested against that threshold and then discarded. The flag is set only when the test is true, and the test is greater-than or less-than-or-equal as selected per slot. A level compare interrupt is asserted while the interrupt enable is on and any compare-mode flag is set.

There are four ways to clear flags. A write to the start register clears all flags, and it wins over a set in the same cycle. The other three clears act on one flag and lose to a set in the same cycle: writing 1 to the flag bit, reading the result register in fast-clear mode, and writing the result register in fast-clear mode.

Top module: `conv_flag_bank`

Register map (4-bit address): 0x0 start (write only, reads 0); 0x1 mode (bit 0 fast-clear, bit 1 compare interrupt enable); 0x2 compare-enable mask (bit n = slot n); 0x3 operator mask (bit n = 1 selects greater-than for slot n); 0x4 flag status; 0x8+n result register of slot n (bits 11:0). Other addresses read 0.

## Requirements
- R1: The flag status at address 0x4 carries flag n in bit n for n = 0..7, and bits 15:8 always read 0. While fast-clear is on (mode bit 0 = 1), writes to 0x4 leave the flags unchanged.
- R2: A done strobe with slot index n affects only flag bit n and result register n, so slot 4 sets bit 4.
- R3: With compare disabled for slot n, a done strobe sets flag n one cycle later, and result register n then reads the converted value.
- R4: With compare enabled for slot n, a done strobe never changes result register n, which keeps the threshold written over the bus. Flag n is set only if the comparison is true.
- R5: The compare is unsigned on 12 bits. Operator bit n = 1 tests value > threshold, and operator bit n = 0 tests value <= threshold.
- R6: Output cmp_irq is high exactly while mode bit 1 is 1 and at least one flag of a compare-enabled slot is set. It falls once those flags clear.
- R7: Any write to address 0x0 clears all eight flags, even when a done strobe would set one in the same cycle.
- R8: With fast-clear off, a write to 0x4 clears every flag whose data bit is 1 and leaves flags with data bit 0 unchanged.
- R9: With fast-clear on and compare disabled for slot n, a read of result register n returns the stored value and clears flag n. A read of a compare-mode slot's result does not clear its flag.
- R10: With fast-clear on and compare enabled for slot n, a write to result register n loads the new threshold and clears flag n.
- R11: The write-1, read-result and write-result clears lose to a done strobe that sets the same flag in the same cycle, so that flag stays set.
- R12: After reset all flags, result registers, configuration fields and cmp_irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| conv_done | input | 1 | One-cycle conversion-finished strobe |
| conv_slot | input | 3 | Sequence position of the finished conversion |
| conv_value | input | 12 | Converted value |
| cmp_irq | output | 1 | Level compare interrupt request |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that conv_slot and conv_value are meaningful only while conv_done is high. The store and flag-clear properties hold only when no start write or result write to the same slot falls in the cycle they observe, so they are qualified on those events. The bench drives one bus operation per transaction and raises conv_done only together with a valid slot. It places same-cycle set-versus-clear collisions on purpose, to exercise the priority rules.

// File: rtl/conv_flag_pkg.sv
package conv_flag_pkg;

    localparam int unsigned NSLOT  = 8;
    localparam int unsigned SLOT_W = $clog2(NSLOT);
    localparam int unsigned VAL_W  = 12;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADR_W  = 4;

    localparam logic [ADR_W-1:0] A_START = 4'h0;
    localparam logic [ADR_W-1:0] A_MODE  = 4'h1;
    localparam logic [ADR_W-1:0] A_CMPEN = 4'h2;
    localparam logic [ADR_W-1:0] A_CMPOP = 4'h3;
    localparam logic [ADR_W-1:0] A_FLAGS = 4'h4;

    typedef struct packed {
        logic             fast_clr;
        logic             irq_en;
        logic [NSLOT-1:0] cmp_en;
        logic [NSLOT-1:0] cmp_gt;
    } cfg_t;

    typedef struct packed {
        logic             flag;
        logic [VAL_W-1:0] res;
    } slot_t;

endpackage

// File: rtl/conv_flag_cfg.sv
module conv_flag_cfg
    import conv_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [ADR_W-1:0] addr,
    input  logic [NSLOT-1:0] wbyte,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            unique case (addr)
                A_MODE: begin
                    cfg_d.fast_clr = wbyte[0];
                    cfg_d.irq_en   = wbyte[1];
                end
                A_CMPEN: cfg_d.cmp_en = wbyte;
                A_CMPOP: cfg_d.cmp_gt = wbyte;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/conv_flag_slot.sv
module conv_flag_slot
    import conv_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_clr,
    input  logic             done,
    input  logic [VAL_W-1:0] value,
    input  logic             cmp_en,
    input  logic             cmp_gt,
    input  logic             fast_clr,
    input  logic             w1c,
    input  logic             rd_hit,
    input  logic             wr_hit,
    input  logic [VAL_W-1:0] wr_val,
    output logic             flag,
    output logic [VAL_W-1:0] result
);
    slot_t s_d, s_q;
    logic  cmp_true, set_hit, soft_clr;

    always_comb begin
        s_d      = s_q;
        cmp_true = cmp_gt ? (value > s_q.res) : (value <= s_q.res);
        set_hit  = done && (!cmp_en || cmp_true);
        soft_clr = (!fast_clr && w1c)
                 || (fast_clr && !cmp_en && rd_hit)
                 || (fast_clr &&  cmp_en && wr_hit);

        // bus load of the register first; a stored conversion overrides it
        if (wr_hit)           s_d.res = wr_val;
        if (done && !cmp_en)  s_d.res = value;

        // start clear > set > single-flag clears
        if (start_clr)        s_d.flag = 1'b0;
        else if (set_hit)     s_d.flag = 1'b1;
        else if (soft_clr)    s_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag   = s_q.flag;
    assign result = s_q.res;
endmodule

// File: rtl/conv_flag_rdmux.sv
module conv_flag_rdmux
    import conv_flag_pkg::*;
(
    input  logic [ADR_W-1:0]            addr,
    input  cfg_t                        cfg,
    input  logic [NSLOT-1:0]            flags,
    input  logic [NSLOT-1:0][VAL_W-1:0] results,
    output logic [BUS_W-1:0]            rdata
);
    localparam int unsigned PAD_B = BUS_W - NSLOT;
    localparam int unsigned PAD_R = BUS_W - VAL_W;

    always_comb begin
        rdata = '0;
        if (addr[ADR_W-1]) begin
            rdata = {{PAD_R{1'b0}}, results[addr[SLOT_W-1:0]]};
        end else begin
            unique case (addr)
                A_MODE:  rdata = {{(BUS_W-2){1'b0}}, cfg.irq_en, cfg.fast_clr};
                A_CMPEN: rdata = {{PAD_B{1'b0}}, cfg.cmp_en};
                A_CMPOP: rdata = {{PAD_B{1'b0}}, cfg.cmp_gt};
                A_FLAGS: rdata = {{PAD_B{1'b0}}, flags};
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/conv_flag_bank.sv
module conv_flag_bank
    import conv_flag_pkg::*;
#(
    parameter int unsigned N_SLOT = NSLOT,
    parameter int unsigned SW     = SLOT_W,
    parameter int unsigned VW     = VAL_W,
    parameter int unsigned BW     = BUS_W,
    parameter int unsigned AW     = ADR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          conv_done,
    input  logic [SW-1:0] conv_slot,
    input  logic [VW-1:0] conv_value,
    output logic          cmp_irq
);
    localparam logic RES_SPACE = 1'b1;

    cfg_t                         cfg;
    logic [N_SLOT-1:0]            flag_vec;
    logic [N_SLOT-1:0][VW-1:0]    res_vec;
    logic                         start_wr, flags_wr, res_acc;

    assign start_wr = bus_wr && (bus_addr == A_START);
    assign flags_wr = bus_wr && (bus_addr == A_FLAGS);
    assign res_acc  = (bus_addr[AW-1] == RES_SPACE);

    conv_flag_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wbyte (bus_wdata[N_SLOT-1:0]),
        .cfg   (cfg)
    );

    for (genvar n = 0; n < N_SLOT; n++) begin : g_slot
        logic sel;
        assign sel = res_acc && (bus_addr[SW-1:0] == SW'(n));

        conv_flag_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_clr (start_wr),
            .done      (conv_done && (conv_slot == SW'(n))),
            .value     (conv_value),
            .cmp_en    (cfg.cmp_en[n]),
            .cmp_gt    (cfg.cmp_gt[n]),
            .fast_clr  (cfg.fast_clr),
            .w1c       (flags_wr && bus_wdata[n]),
            .rd_hit    (bus_rd && sel),
            .wr_hit    (bus_wr && sel),
            .wr_val    (bus_wdata[VW-1:0]),
            .flag      (flag_vec[n]),
            .result    (res_vec[n])
        );
    end

    conv_flag_rdmux u_rdmux (
        .addr    (bus_addr),
        .cfg     (cfg),
        .flags   (flag_vec),
        .results (res_vec),
        .rdata   (bus_rdata)
    );

    assign cmp_irq = cfg.irq_en && |(flag_vec & cfg.cmp_en);
endmodule

// File: rtl/conv_flag_chk.sv
module conv_flag_chk
    import conv_flag_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic                        bus_rd,
    input logic [ADR_W-1:0]            bus_addr,
    input logic [BUS_W-1:0]            bus_wdata,
    input logic [BUS_W-1:0]            bus_rdata,
    input logic                        conv_done,
    input logic [SLOT_W-1:0]           conv_slot,
    input logic [VAL_W-1:0]            conv_value,
    input logic [NSLOT-1:0]            flag_vec,
    input logic [NSLOT-1:0][VAL_W-1:0] res_vec,
    input cfg_t                        cfg
);
    logic start_w, slot_res_w;
    assign start_w    = bus_wr && bus_addr == A_START;
    assign slot_res_w = bus_wr && bus_addr == {1'b1, conv_slot};

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_FLAGS) |-> bus_rdata[BUS_W-1:NSLOT] == '0);

    a_r3_store_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !cfg.cmp_en[conv_slot] && !start_w)
        |=> flag_vec[$past(conv_slot)] && res_vec[$past(conv_slot)] == $past(conv_value));

    a_r4_cmp_keeps_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cfg.cmp_en[conv_slot] && !slot_res_w)
        |=> res_vec[$past(conv_slot)] == $past(res_vec[conv_slot]));

    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> flag_vec == '0);

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FLAGS && !cfg.fast_clr && !conv_done)
        |=> (flag_vec & $past(bus_wdata[NSLOT-1:0])) == '0);
endmodule

bind conv_flag_bank conv_flag_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .conv_done  (conv_done),
    .conv_slot  (conv_slot),
    .conv_value (conv_value),
    .flag_vec   (flag_vec),
    .res_vec    (res_vec),
    .cfg        (cfg)
);

// File: tb/conv_flag_bank_test.sv
module conv_flag_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        conv_done = 1'b0;
    logic [2:0]  conv_slot = '0;
    logic [11:0] conv_value = '0;
    logic        cmp_irq;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    typedef struct { logic [15:0] exp; string tag; } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    conv_flag_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_done(conv_done), .conv_slot(conv_slot), .conv_value(conv_value),
        .cmp_irq(cmp_irq)
    );

    // monitor: pops expected read data while a read strobe is held
    always @(negedge clk) begin
        if (bus_rd) begin
            n_run++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    // one clock of bus activity plus an optional conversion strobe
    task automatic op(input bit wr, input bit rd, input logic [3:0] a,
                      input logic [15:0] wd, input bit dn, input logic [2:0] sl,
                      input logic [11:0] v, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        conv_done = dn; conv_slot = sl; conv_value = v;
        if (rd) sb.push_back('{exp, tag});
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0; conv_done = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        op(1, 0, a, d, 0, 0, 0, 0, "");
    endtask
    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        op(0, 1, a, 0, 0, 0, 0, e, tag);
    endtask
    task automatic conv(input logic [2:0] s, input logic [11:0] v);
        op(0, 0, 0, 0, 1, s, v, 0, "");
    endtask
    task automatic chk_irq(input bit e, input string tag);
        n_run++;
        if (cmp_irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, cmp_irq, e);
        end
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R12 reset state
        chk_irq(0, "R12 irq after reset");
        rd(4'h4, 16'h0000, "R12 flags after reset");
        rd(4'hB, 16'h0000, "R12 result3 after reset");
        rd(4'h1, 16'h0000, "R12 mode after reset");

        // R2 / R3: fifth conversion sets bit 4 and stores its value
        conv(3'd4, 12'hABC);
        rd(4'h4, 16'h0010, "R2 only bit4 set");
        rd(4'hC, 16'h0ABC, "R3 result4 stored");

        // R1 upper byte and R8 write-0 / write-1
        wr(4'h4, 16'hFF00);
        rd(4'h4, 16'h0010, "R1 upper zero, R8 zero bits keep");
        wr(4'h4, 16'h0010);
        rd(4'h4, 16'h0000, "R8 write one clears");

        // R7 start clears, including same-cycle set
        conv(3'd1, 12'h011);
        conv(3'd2, 12'h022);
        rd(4'h4, 16'h0006, "R3 two slots set");
        wr(4'h0, 16'h0000);
        rd(4'h4, 16'h0000, "R7 start clears all");
        op(1, 0, 4'h0, 0, 1, 3'd3, 12'h033, 0, "");
        rd(4'h4, 16'h0000, "R7 start beats set");

        // R11 write-one clear loses to set
        conv(3'd5, 12'h055);
        op(1, 0, 4'h4, 16'h0020, 1, 3'd5, 12'h056, 0, "");
        rd(4'h4, 16'h0020, "R11 set beats w1c");
        wr(4'h4, 16'h0020);

        // R4 / R5 compare mode
        wr(4'h2, 16'h0003);
        wr(4'h3, 16'h0001);
        wr(4'h8, 16'h0100);
        wr(4'h9, 16'h0200);
        conv(3'd0, 12'h100);
        rd(4'h4, 16'h0000, "R5 gt false at equal");
        rd(4'h8, 16'h0100, "R4 threshold kept");
        conv(3'd0, 12'h101);
        rd(4'h4, 16'h0001, "R5 gt true");
        conv(3'd1, 12'h201);
        rd(4'h4, 16'h0001, "R5 le false above");
        conv(3'd1, 12'h200);
        rd(4'h4, 16'h0003, "R5 le true at equal");
        rd(4'h9, 16'h0200, "R4 threshold1 kept");

        // R6 level interrupt
        chk_irq(0, "R6 irq disabled");
        wr(4'h1, 16'h0002);
        chk_irq(1, "R6 irq raised");
        wr(4'h4, 16'h0003);
        chk_irq(0, "R6 irq drops");

        // R10 / R1 fast-clear compare slot
        wr(4'h1, 16'h0003);
        conv(3'd0, 12'h300);
        chk_irq(1, "R6 irq on compare hit");
        wr(4'h4, 16'h0001);
        rd(4'h4, 16'h0001, "R1 fast-clear write ignored");
        rd(4'h8, 16'h0100, "R9 compare-slot read");
        rd(4'h4, 16'h0001, "R9 compare read no clear");
        wr(4'h8, 16'h0050);
        rd(4'h4, 16'h0000, "R10 result write clears");
        chk_irq(0, "R10 irq drops");
        rd(4'h8, 16'h0050, "R10 new threshold");

        // R9 / R11 fast-clear store slot
        conv(3'd6, 12'h123);
        rd(4'h4, 16'h0040, "R9 flag6 set");
        rd(4'hE, 16'h0123, "R9 read result6");
        rd(4'h4, 16'h0000, "R9 read clears");
        conv(3'd6, 12'h124);
        op(0, 1, 4'hE, 0, 1, 3'd6, 12'h125, 16'h0124, "R11 read old value");
        rd(4'h4, 16'h0040, "R11 set beats read clear");

        // R11 result write clear loses to set in compare slot
        conv(3'd1, 12'h010);
        op(1, 0, 4'h9, 16'h0200, 1, 3'd1, 12'h020, 0, "");
        rd(4'h4, 16'h0042, "R11 set beats result write");

        repeat (2) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule